// File: doc/BRIEF.md
# Synchronous Memory Clock and First-Data Latency Sequencer

This block drives the clock of an external synchronous memory during a burst access. It derives that clock from the system clock with a programmable divide code. It then counts the rising edges of the divided clock until the first data word of the burst is due. A start strobe opens a sequence. At that moment the block latches one timing word, made of a divide code and a latency code. When split timing is enabled, a write access takes the write word and every other access takes the read word.

While a sequence runs, the block produces the memory clock and a one-cycle enable on each of its rising edges. On the rising edge where the latency runs out, it gives a single first-data pulse. The sequence then ends and the clock parks low. If the synchronous enable is low, a start strobe has no effect and no clock is produced.

Top module: `smclk_seq`

## Requirements
- R1: In this requirement, P is the divided clock period and L = floor(P/2). P equals the effective divide code plus 1 system cycles, so code 1 gives 2 and code 15 gives 16. Take a start accepted at clock edge t. After edges t+j, `mem_clk` is high exactly when (j mod P) >= L. This means the clock starts low, stays low for L cycles and stays high for P-L cycles.
- R2: A divide code of 0 behaves exactly like code 1, giving a period of 2 system cycles.
- R3: `clk_edge_en` is high for exactly the first system cycle of each high phase of `mem_clk`, which is the cycle where (j mod P) == L.
- R4: `first_data` is high for one cycle, coincident with the N-th rising edge of `mem_clk`, where N = latency code + 2 (code 0 gives 2, code 15 gives 17). That cycle is j = L + (N-1)·P.
- R5: In the cycle after the `first_data` pulse, `mem_clk`, `clk_edge_en` and `first_data` are low, and they stay low until a new start is accepted.
- R6: A start strobe while `sync_en` is low is ignored. No clock, edge enable or first-data pulse follows it.
- R7: A start strobe during a running sequence is ignored, including one in the cycle of the `first_data` pulse. Changes to the timing inputs, `ext_mode` or `is_write` during a sequence do not alter its timing.
- R8: With `ext_mode` high and `is_write` high, the write word (`wr_div`, `wr_lat`) is used. In every other case the read word (`rd_div`, `rd_lat`) is used.
- R9: While reset is asserted and after its release before any start, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | Access is a synchronous burst; a start is only accepted when high |
| ext_mode | input | 1 | Use separate read and write timing words |
| is_write | input | 1 | Access direction, high for write |
| start | input | 1 | Start-of-access strobe |
| rd_div | input | 4 | Read-word divide code |
| rd_lat | input | 4 | Read-word latency code |
| wr_div | input | 4 | Write-word divide code |
| wr_lat | input | 4 | Write-word latency code |
| mem_clk | output | 1 | Divided memory clock |
| clk_edge_en | output | 1 | One-cycle pulse on each rising memory clock edge |
| first_data | output | 1 | One-cycle pulse when the first burst data is due |

## Verification
The edge enable and the first-data pulse fall in the same system cycle when the latency expires. A fresh start strobe can also land in that very cycle, when the sequence is still formally busy. Short sequences with latency code 0 and divide codes 0 to 2 make these events come within a few cycles of each other. Random runs also drive noise strobes and scrambled timing inputs in every cycle of a sequence, the pulse cycle included. Each cycle is judged against a model that computes the expected clock level, edge enable and pulse from the period, the low-phase length and the rise count. The bench then confirms that the cycles after the pulse stay idle.

// File: rtl/smclk_pkg.sv
package smclk_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // divide code actually used: 0 is remapped so the clock never stalls
  function automatic int unsigned eff_div(input int unsigned code);
    return (code == 0) ? 1 : code;
  endfunction

  // divided clock period in system cycles
  function automatic int unsigned clk_period(input int unsigned code);
    return eff_div(code) + 1;
  endfunction

  // length of the low phase in system cycles
  function automatic int unsigned low_len(input int unsigned code);
    return clk_period(code) / 2;
  endfunction

  // number of divided-clock rising edges up to first data
  function automatic int unsigned first_lat(input int unsigned code,
                                            input int unsigned offs);
    return code + offs;
  endfunction

endpackage

// File: rtl/smclk_word_sel.sv
module smclk_word_sel #(
  parameter int FIELD_W = 4
) (
  input  logic               ext_mode,
  input  logic               is_write,
  input  logic [FIELD_W-1:0] rd_div,
  input  logic [FIELD_W-1:0] rd_lat,
  input  logic [FIELD_W-1:0] wr_div,
  input  logic [FIELD_W-1:0] wr_lat,
  output logic               use_wr,
  output logic [FIELD_W-1:0] sel_div,
  output logic [FIELD_W-1:0] sel_lat
);

  always_comb begin
    use_wr  = ext_mode & is_write;
    sel_div = use_wr ? wr_div : rd_div;
    sel_lat = use_wr ? wr_lat : rd_lat;
  end

  always_comb begin
    // R8
    word_pick_chk: assert (use_wr || (sel_div == rd_div && sel_lat == rd_lat));
  end

endmodule

// File: rtl/smclk_divider.sv
module smclk_divider #(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               run,
  input  logic [FIELD_W-1:0] div_code,
  output logic               mem_clk,
  output logic               rise_evt,
  output logic               edge_en
);
  import smclk_pkg::*;

  localparam int MAX_PER = 2 ** FIELD_W;
  localparam int PH_W    = $clog2(MAX_PER);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_n;
  logic [PH_W-1:0] per_m1;
  logic [PH_W-1:0] low_w;
  logic            clk_q;
  logic            edge_q;

  always_comb begin
    per_m1   = PH_W'(clk_period(int'(div_code)) - 1);
    low_w    = PH_W'(low_len(int'(div_code)));
    phase_n  = (phase_q == per_m1) ? '0 : phase_q + PH_W'(1);
    rise_evt = run && (phase_n == low_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      clk_q   <= 1'b0;
      edge_q  <= 1'b0;
    end else if (load || !run) begin
      phase_q <= '0;
      clk_q   <= 1'b0;
      edge_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      clk_q   <= (phase_n >= low_w);
      edge_q  <= rise_evt;
    end
  end

  assign mem_clk = clk_q;
  assign edge_en = edge_q;

  // R3
  edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_en |-> (mem_clk && !$past(mem_clk)));

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (phase_q <= per_m1));

  // R1
  low_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !mem_clk);

endmodule

// File: rtl/smclk_latency.sv
module smclk_latency #(
  parameter int FIELD_W = 4,
  parameter int LAT_OFS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               run,
  input  logic               rise_evt,
  input  logic [FIELD_W-1:0] lat_code,
  output logic               first_data
);
  import smclk_pkg::*;

  localparam int MAX_LAT = (2 ** FIELD_W) - 1 + LAT_OFS;
  localparam int LC_W    = $clog2(MAX_LAT + 1);

  logic [LC_W-1:0] rises_q;
  logic [LC_W-1:0] tgt_m1;
  logic            last_rise;
  logic            rdy_q;

  always_comb begin
    tgt_m1    = LC_W'(first_lat(int'(lat_code), LAT_OFS) - 1);
    last_rise = run && rise_evt && (rises_q == tgt_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises_q <= '0;
      rdy_q   <= 1'b0;
    end else if (load) begin
      rises_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      if (run && rise_evt) rises_q <= rises_q + LC_W'(1);
      rdy_q <= last_rise;
    end
  end

  assign first_data = rdy_q;

  // R4
  rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_data |=> !first_data);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rises_q <= tgt_m1));

endmodule

// File: rtl/smclk_seq.sv
module smclk_seq #(
  parameter int FIELD_W = 4,
  parameter int LAT_OFS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_en,
  input  logic               ext_mode,
  input  logic               is_write,
  input  logic               start,
  input  logic [FIELD_W-1:0] rd_div,
  input  logic [FIELD_W-1:0] rd_lat,
  input  logic [FIELD_W-1:0] wr_div,
  input  logic [FIELD_W-1:0] wr_lat,
  output logic               mem_clk,
  output logic               clk_edge_en,
  output logic               first_data
);
  import smclk_pkg::*;

  seq_state_e         state_q;
  logic               busy;
  logic               accept;
  logic               run;
  logic               use_wr;
  logic [FIELD_W-1:0] sel_div;
  logic [FIELD_W-1:0] sel_lat;
  logic [FIELD_W-1:0] div_q;
  logic [FIELD_W-1:0] lat_q;
  logic               rise_evt;

  smclk_word_sel #(.FIELD_W(FIELD_W)) u_sel (
    .ext_mode (ext_mode),
    .is_write (is_write),
    .rd_div   (rd_div),
    .rd_lat   (rd_lat),
    .wr_div   (wr_div),
    .wr_lat   (wr_lat),
    .use_wr   (use_wr),
    .sel_div  (sel_div),
    .sel_lat  (sel_lat)
  );

  assign busy   = (state_q == SEQ_RUN);
  assign accept = start && sync_en && !busy;
  assign run    = busy && !first_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      div_q   <= '0;
      lat_q   <= '0;
    end else if (accept) begin
      state_q <= SEQ_RUN;
      div_q   <= sel_div;
      lat_q   <= sel_lat;
    end else if (first_data) begin
      state_q <= SEQ_IDLE;
    end
  end

  smclk_divider #(.FIELD_W(FIELD_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .run      (run),
    .div_code (div_q),
    .mem_clk  (mem_clk),
    .rise_evt (rise_evt),
    .edge_en  (clk_edge_en)
  );

  smclk_latency #(.FIELD_W(FIELD_W), .LAT_OFS(LAT_OFS)) u_lat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .run        (run),
    .rise_evt   (rise_evt),
    .lat_code   (lat_q),
    .first_data (first_data)
  );

  // R4
  rdy_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_data |-> clk_edge_en);

  // R5
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_data |=> (!busy && !mem_clk && !clk_edge_en));

  // R6
  async_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !sync_en) |=> !busy);

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !first_data) |=> ($stable(div_q) && $stable(lat_q) && busy));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_clk && !clk_edge_en && !first_data));

endmodule

// File: tb/smclk_seq_test.sv
module smclk_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_en = 1'b0, ext_mode = 1'b0, is_write = 1'b0, start = 1'b0;
  logic [3:0] rd_div = 4'd0, rd_lat = 4'd0, wr_div = 4'd0, wr_lat = 4'd0;
  logic       mem_clk, clk_edge_en, first_data;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smclk_seq uut (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .ext_mode(ext_mode),
    .is_write(is_write), .start(start), .rd_div(rd_div), .rd_lat(rd_lat),
    .wr_div(wr_div), .wr_lat(wr_lat), .mem_clk(mem_clk),
    .clk_edge_en(clk_edge_en), .first_data(first_data)
  );

  function automatic int per_of(input int code);
    int d;
    d = (code == 0) ? 1 : code;
    return d + 1;
  endfunction

  function automatic int rise_count(input int code);
    return code + 2;
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic check_quiet(input string req);
    check(req, "mem_clk", mem_clk, 1'b0);
    check(req, "clk_edge_en", clk_edge_en, 1'b0);
    check(req, "first_data", first_data, 1'b0);
  endtask

  // run one accepted sequence and check every cycle of it
  task automatic run_seq(input int rdv, input int rdl, input int wrv, input int wrl,
                         input logic ext, input logic wr, input bit noise);
    int p, l, n, last, dv, lt;
    string rq;
    @(negedge clk);
    rd_div = 4'(rdv); rd_lat = 4'(rdl); wr_div = 4'(wrv); wr_lat = 4'(wrl);
    ext_mode = ext; is_write = wr; sync_en = 1'b1; start = 1'b1;
    dv = (ext && wr) ? wrv : rdv;
    lt = (ext && wr) ? wrl : rdl;
    p = per_of(dv);
    l = p / 2;
    n = rise_count(lt);
    last = l + (n - 1) * p;
    rq = (dv == 0) ? "R2" : (ext ? "R8" : "R1");
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= last + 2; j++) begin
      if (j <= last) begin
        check(rq, "mem_clk", mem_clk, ((j % p) >= l));
        check(noise ? "R7" : "R3", "clk_edge_en", clk_edge_en, ((j % p) == l));
        check(noise ? "R7" : "R4", "first_data", first_data, (j == last));
      end else begin
        check_quiet("R5");
      end
      if (noise && j <= last) begin
        start = 1'($urandom_range(0, 1));
        rd_div = 4'($urandom); rd_lat = 4'($urandom);
        wr_div = 4'($urandom); wr_lat = 4'($urandom);
        ext_mode = 1'($urandom); is_write = 1'($urandom);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset state
    repeat (3) @(negedge clk);
    check_quiet("R9");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_quiet("R9");

    // directed corners
    run_seq(1, 0, 0, 0, 1'b0, 1'b0, 1'b0);     // R1 shortest
    run_seq(15, 15, 0, 0, 1'b0, 1'b0, 1'b0);   // R1 R4 longest
    run_seq(0, 3, 0, 0, 1'b0, 1'b0, 1'b0);     // R2 code 0
    run_seq(2, 1, 0, 0, 1'b0, 1'b0, 1'b0);     // R1 odd period
    run_seq(3, 2, 9, 5, 1'b1, 1'b1, 1'b0);     // R8 write word
    run_seq(3, 2, 9, 5, 1'b1, 1'b0, 1'b0);     // R8 read word in split mode
    run_seq(4, 1, 12, 7, 1'b0, 1'b1, 1'b0);    // R8 single word for write
    run_seq(1, 0, 0, 0, 1'b0, 1'b0, 1'b1);     // R7 noise on shortest

    // R6: asynchronous start ignored
    @(negedge clk);
    sync_en = 1'b0; rd_div = 4'd1; rd_lat = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 40; k++) begin
      check_quiet("R6");
      @(negedge clk);
    end

    // random sequences
    for (int i = 0; i < 80; i++) begin
      run_seq(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
              int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
              1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule